// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Generator

This block sits in a streaming video pipeline ahead of any luma/chroma conversion and remaps each red, green and blue component through a programmable transfer curve. The curve is made of sixteen straight segments over the 8-bit input range. The upper four bits of a component pick a segment, and the lower four bits pick a position inside it. Each segment holds a start level and a non-negative slope. When each segment's start level equals the end of the segment before it, the curve is continuous and never falls. The start level of the first segment and the slopes of the last ones set the black and white levels, so the same table gives contrast and range adjustment as well as gamma.

One pixel is accepted per clock, and every result leaves exactly two clocks later with its valid and sync flags. Software-side logic writes the segment table through a simple write port. Writes go to a staging copy, and that copy becomes the live curve on the next rising edge of vertical sync, so a field is never processed with a half-updated curve. After reset the live curve is the identity.

Top module: `gamma_pwl`

## Requirements
- R1: After reset, and before any table load, each output component equals its input component.
- R2: With table entry k = in[7:4] holding start level B and slope S (unsigned, 4 fractional bits), each output component is B + floor((S * in[3:0] + 8) / 16). R, G and B share one table but are evaluated independently.
- R3: When that sum exceeds 255 the output component is 255.
- R4: Output data, out_valid, out_hsync and out_vsync appear exactly 2 clocks after the corresponding inputs. A pixel presented for one cycle gives out_valid low 1 clock later and high 2 clocks later.
- R5: A write with wr_en high stores wr_data into the staging table: wr_addr[3:0] selects the segment, wr_addr[4]=0 selects the start level, and wr_addr[4]=1 selects the slope. Until the next load, staged writes have no effect on the outputs.
- R6: A rising edge of in_vsync (high in this cycle, low in the previous one) copies the whole staging table into the live table. A pixel presented in the same cycle as that edge still uses the old curve, and pixels from the following cycle onward use the new one.
- R7: While rst_n is low at a clock edge, all outputs are driven to zero after that edge.
- R8: With a table whose entries join (start level of k+1 = start level of k + slope of k in raw units), the output over all 256 input codes never decreases as the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| in_hsync | input | 1 | Horizontal sync flag travelling with the pixel |
| in_vsync | input | 1 | Vertical sync flag; its rising edge loads the live table |
| in_r | input | 8 | Red component in |
| in_g | input | 8 | Green component in |
| in_b | input | 8 | Blue component in |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 5 | Bit 4 field select (0 start level, 1 slope), bits 3:0 segment |
| wr_data | input | 8 | Value written |
| out_valid | output | 1 | Delayed pixel qualifier |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |

## Verification
Each pixel and flag is due two clocks after it is driven. The bench drives on the falling edge and samples on the second falling edge after that. It also samples the first falling edge to confirm that out_valid is still low. A table write or a vsync edge changes only the pixels driven after the load. The bench therefore keeps a staging model and a live model, and updates the live model at the same falling edge where it drives the vsync edge. The check on pixels in the same cycle as the edge expects the old curve for the first pixel and the new curve for the next.

// File: rtl/gamma_pwl_pkg.sv
// Shared types for the gamma curve generator.
// Assumes: flags travel alongside data through each pipeline stage.
package gamma_pwl_pkg;

    // Sideband flags that accompany every pixel through the pipeline
    typedef struct packed {
        logic valid;
        logic hsync;
        logic vsync;
    } pix_flags_t;

    localparam int NUM_CH = 3;

endpackage

// File: rtl/gamma_regbank.sv
// Segment table with staging and live copies.
// Writes land in the staging copy. A load pulse copies the whole staging
// copy into the live copy in one cycle. Both copies reset to the identity curve.
// Assumes: SLOPE_W <= DATA_W, and STEP_SH == FRAC_W for the identity to be exact.
module gamma_regbank #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 4,
    parameter int SLOPE_W  = 8,
    parameter int FRAC_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [SEG_BITS-1:0] wr_seg,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                load,
    output logic [DATA_W-1:0]   act_base  [2**SEG_BITS],
    output logic [SLOPE_W-1:0]  act_slope [2**SEG_BITS]
);
    localparam int SEG_N   = 2**SEG_BITS;
    localparam int STEP_SH = DATA_W - SEG_BITS;

    logic [DATA_W-1:0]  shd_base  [SEG_N];
    logic [SLOPE_W-1:0] shd_slope [SEG_N];

    // Staging copy: reset to identity, then take writes
    always_ff @(posedge clk) begin
        for (int k = 0; k < SEG_N; k++) begin
            if (!rst_n) begin
                shd_base[k]  <= DATA_W'(k << STEP_SH);
                shd_slope[k] <= SLOPE_W'(1 << FRAC_W);
            end else if (wr_en && wr_seg == SEG_BITS'(k)) begin
                if (!wr_sel) shd_base[k]  <= wr_data;
                else         shd_slope[k] <= wr_data[SLOPE_W-1:0];
            end
        end
    end

    // Live copy: reset to identity, then refresh from staging on a load
    always_ff @(posedge clk) begin
        for (int k = 0; k < SEG_N; k++) begin
            if (!rst_n) begin
                act_base[k]  <= DATA_W'(k << STEP_SH);
                act_slope[k] <= SLOPE_W'(1 << FRAC_W);
            end else if (load) begin
                act_base[k]  <= shd_base[k];
                act_slope[k] <= shd_slope[k];
            end
        end
    end

endmodule

// File: rtl/gamma_seg_eval.sv
// Two-stage evaluator for one colour component.
// Stage 1 looks up the segment and forms the rounded product of slope and offset.
// Stage 2 adds the start level and saturates.
// Assumes: the live table is stable for the pixel's stage-1 cycle.
module gamma_seg_eval #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 4,
    parameter int SLOPE_W  = 8,
    parameter int FRAC_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  pix_in,
    input  logic [DATA_W-1:0]  act_base  [2**SEG_BITS],
    input  logic [SLOPE_W-1:0] act_slope [2**SEG_BITS],
    output logic [DATA_W-1:0]  pix_out
);
    localparam int LOW_W  = DATA_W - SEG_BITS;
    localparam int PROD_W = SLOPE_W + LOW_W + 1;
    localparam int SUM_W  = ((PROD_W > DATA_W) ? PROD_W : DATA_W) + 1;
    localparam int RND    = 1 << (FRAC_W - 1);
    localparam logic [DATA_W-1:0] MAX_V = '1;

    logic [SEG_BITS-1:0] seg;
    logic [LOW_W-1:0]    low;
    logic [DATA_W-1:0]   base_q;
    logic [PROD_W-1:0]   prod_q;
    logic [SUM_W-1:0]    sum;

    // Split the component into segment index and in-segment offset
    always_comb begin
        seg = pix_in[DATA_W-1 -: SEG_BITS];
        low = pix_in[LOW_W-1:0];
    end

    // Stage 1: fetch start level, form rounded slope product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            prod_q <= '0;
        end else begin
            base_q <= act_base[seg];
            prod_q <= PROD_W'(act_slope[seg]) * PROD_W'(low) + PROD_W'(RND);
        end
    end

    // Stage 2 sum: start level plus integer part of the product
    always_comb sum = SUM_W'(base_q) + SUM_W'(prod_q >> FRAC_W);

    // Stage 2 register: saturate to the top code
    always_ff @(posedge clk) begin
        if (!rst_n)                         pix_out <= '0;
        else if (sum > SUM_W'(MAX_V))       pix_out <= MAX_V;
        else                                pix_out <= sum[DATA_W-1:0];
    end

endmodule

// File: rtl/gamma_pwl.sv
// Top of the gamma curve generator.
// Applies one shared piecewise-linear curve to R, G and B with a fixed 2-clock
// latency. A rising vsync edge loads the staged table into the live table.
// Assumes: one pixel per clock at most, qualified by in_valid.
module gamma_pwl
    import gamma_pwl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 4,
    parameter int SLOPE_W  = 8,
    parameter int FRAC_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_hsync,
    input  logic                in_vsync,
    input  logic [DATA_W-1:0]   in_r,
    input  logic [DATA_W-1:0]   in_g,
    input  logic [DATA_W-1:0]   in_b,
    input  logic                wr_en,
    input  logic [SEG_BITS:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                out_valid,
    output logic                out_hsync,
    output logic                out_vsync,
    output logic [DATA_W-1:0]   out_r,
    output logic [DATA_W-1:0]   out_g,
    output logic [DATA_W-1:0]   out_b
);
    localparam int SEG_N = 2**SEG_BITS;

    logic               vs_q;
    logic               tbl_load;
    logic [DATA_W-1:0]  act_base  [SEG_N];
    logic [SLOPE_W-1:0] act_slope [SEG_N];
    logic [DATA_W-1:0]  ch_in  [NUM_CH];
    logic [DATA_W-1:0]  ch_out [NUM_CH];
    pix_flags_t         flg_s1, flg_s2;

    // Remember previous vsync for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= in_vsync;
    end

    // Load the live table on a rising vsync
    always_comb tbl_load = in_vsync & ~vs_q;

    gamma_regbank #(
        .DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_addr[SEG_BITS]),
        .wr_seg    (wr_addr[SEG_BITS-1:0]),
        .wr_data   (wr_data),
        .load      (tbl_load),
        .act_base  (act_base),
        .act_slope (act_slope)
    );

    // Gather the components for the per-channel evaluators
    always_comb begin
        ch_in[0] = in_r;
        ch_in[1] = in_g;
        ch_in[2] = in_b;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gamma_seg_eval #(
            .DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W)
        ) u_eval (
            .clk       (clk),
            .rst_n     (rst_n),
            .pix_in    (ch_in[c]),
            .act_base  (act_base),
            .act_slope (act_slope),
            .pix_out   (ch_out[c])
        );
    end

    // Delay the flags through the same two stages as the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_s1 <= '0;
            flg_s2 <= '0;
        end else begin
            flg_s1 <= '{valid: in_valid, hsync: in_hsync, vsync: in_vsync};
            flg_s2 <= flg_s1;
        end
    end

    // Drive the output ports
    always_comb begin
        out_valid = flg_s2.valid;
        out_hsync = flg_s2.hsync;
        out_vsync = flg_s2.vsync;
        out_r     = ch_out[0];
        out_g     = ch_out[1];
        out_b     = ch_out[2];
    end

endmodule

// File: rtl/gamma_pwl_chk.sv
// Property checker for the gamma curve generator, attached by bind.
// Assumes: rst_n is synchronous, so a cycle counter since release guards $past.
module gamma_pwl_chk #(
    parameter int DATA_W   = 8,
    parameter int SEG_BITS = 4,
    parameter int SLOPE_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_hsync,
    input logic               in_vsync,
    input logic               tbl_load,
    input logic               out_valid,
    input logic               out_hsync,
    input logic               out_vsync,
    input logic [DATA_W-1:0]  out_r,
    input logic [DATA_W-1:0]  out_g,
    input logic [DATA_W-1:0]  out_b,
    input logic [DATA_W-1:0]  act_base  [2**SEG_BITS],
    input logic [SLOPE_W-1:0] act_slope [2**SEG_BITS]
);
    logic [1:0] since_rst;

    // Count cycles since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    p_valid_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2) |-> (out_valid == $past(in_valid, 2)));

    p_hsync_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2) |-> (out_hsync == $past(in_hsync, 2)));

    p_vsync_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2) |-> (out_vsync == $past(in_vsync, 2)));

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_hsync && !out_vsync &&
                    out_r == '0 && out_g == '0 && out_b == '0));

    for (genvar k = 0; k < 2**SEG_BITS; k++) begin : g_hold
        p_table_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 1 && !$past(tbl_load)) |->
                ($stable(act_base[k]) && $stable(act_slope[k])));
    end

endmodule

bind gamma_pwl gamma_pwl_chk #(
    .DATA_W(DATA_W), .SEG_BITS(SEG_BITS), .SLOPE_W(SLOPE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_hsync  (in_hsync),
    .in_vsync  (in_vsync),
    .tbl_load  (tbl_load),
    .out_valid (out_valid),
    .out_hsync (out_hsync),
    .out_vsync (out_vsync),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b),
    .act_base  (act_base),
    .act_slope (act_slope)
);

// File: tb/gamma_pwl_test.sv
// Directed bench for the gamma curve generator: one task per scenario.
// Drives on falling edges and samples on falling edges.
module gamma_pwl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_valid, out_hsync, out_vsync;
    logic [7:0] out_r, out_g, out_b;

    int n_chk = 0;
    int n_bad = 0;
    int m_base[16], m_slope[16], s_base[16], s_slope[16];
    int last_r = 0;

    always #2 clk = ~clk;

    gamma_pwl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hsync(in_hsync),
        .in_vsync(in_vsync), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(int x);
        int s = x >> 4;
        int v = m_base[s] + ((m_slope[s] * (x & 15) + 8) >> 4);
        return (v > 255) ? 255 : v;
    endfunction

    // One pixel; checks out_valid low at +1 and the data at +2
    task automatic send_px(int r, int g, int b, string req);
        @(negedge clk);
        in_valid = 1'b1; in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 valid at +1", int'(out_valid), 0);
        @(negedge clk);
        chk("R4 valid at +2", int'(out_valid), 1);
        chk({req, " red"},   int'(out_r), model(r));
        chk({req, " green"}, int'(out_g), model(g));
        chk({req, " blue"},  int'(out_b), model(b));
        last_r = int'(out_r);
    endtask

    task automatic write_reg(int addr, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
        if (addr < 16) s_base[addr] = data; else s_slope[addr - 16] = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vsync_pulse();
        @(negedge clk);
        in_vsync = 1'b1;
        m_base = s_base; m_slope = s_slope;
        @(negedge clk);
        in_vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7 valid", int'(out_valid), 0);
        chk("R7 hsync", int'(out_hsync), 0);
        chk("R7 vsync", int'(out_vsync), 0);
        chk("R7 data",  int'(out_r) + int'(out_g) + int'(out_b), 0);
    endtask

    task automatic t_identity();
        send_px(0, 255, 127, "R1 identity");
        send_px(16, 15, 200, "R1 identity");
        send_px(99, 1, 240, "R1 identity");
    endtask

    task automatic t_staged();
        write_reg(3, 100);
        write_reg(16 + 3, 8'h28);
        send_px(8'h35, 8'h3f, 8'h30, "R5 staged not live");
        chk("R5 still identity", last_r, 8'h35);
        vsync_pulse();
        send_px(8'h35, 8'h3f, 8'h30, "R2 new segment");
        chk("R2 explicit", last_r, 113);
    endtask

    task automatic t_edge_pixel();
        int old_exp, new_exp;
        write_reg(3, 40);
        old_exp = model(8'h37);
        @(negedge clk);
        in_vsync = 1'b1; in_valid = 1'b1; in_r = 8'h37; in_g = 8'h37; in_b = 8'h37;
        m_base = s_base; m_slope = s_slope;
        new_exp = model(8'h37);
        @(negedge clk);
        in_vsync = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 edge pixel old curve", int'(out_r), old_exp);
        chk("R4 vsync at +2", int'(out_vsync), 1);
        @(negedge clk);
        chk("R6 next pixel new curve", int'(out_g), new_exp);
        chk("R4 vsync cleared", int'(out_vsync), 0);
    endtask

    task automatic t_saturate();
        write_reg(15, 250);
        write_reg(16 + 15, 255);
        vsync_pulse();
        send_px(255, 240, 241, "R3 saturate");
        chk("R3 top code", last_r, 255);
    endtask

    task automatic t_hsync();
        @(negedge clk);
        in_hsync = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        in_hsync = 1'b0; in_valid = 1'b0;
        chk("R4 hsync at +1", int'(out_hsync), 0);
        @(negedge clk);
        chk("R4 hsync at +2", int'(out_hsync), 1);
        @(negedge clk);
        chk("R4 hsync after", int'(out_hsync), 0);
    endtask

    task automatic t_monotone();
        int b = 0;
        int prev = -1;
        for (int k = 0; k < 16; k++) begin
            write_reg(k, b);
            write_reg(16 + k, 31 - 2 * k);
            b += 31 - 2 * k;
            if (b > 255) b = 255;
        end
        vsync_pulse();
        for (int x = 0; x < 256; x++) begin
            send_px(x, 255 - x, x ^ 8'h5a, "R8 sweep");
            if (last_r < prev) chk("R8 non-decreasing", last_r, prev);
            else chk("R8 non-decreasing", 1, 1);
            prev = last_r;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_base[k] = 16 * k; m_slope[k] = 16;
            s_base[k] = 16 * k; s_slope[k] = 16;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_identity();
        t_staged();
        t_edge_pixel();
        t_saturate();
        t_hsync();
        t_monotone();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule